// File: doc/BRIEF.md
# Bit Test and Scan Unit

This execution unit performs single-bit operations on a 16-bit or 32-bit operand. Given an operand, a bit position and an operation code, it can test one bit, or test it and then set, clear or flip it, producing the updated operand and the bit's prior value as a carry flag. It can also scan the operand for its lowest or highest set bit, producing that bit's position and a zero flag that reports whether any bit was set.

A caller presents the operand, index, width select and operation code together with a one-cycle `start_i` pulse. One clock later, the registered results appear and `valid_o` is high for exactly one cycle. Results and flags that an operation does not define keep their previous registered values.

Top module: `bit_ops_unit`

## Requirements
- R1: After reset, `result_o`, `cf_o`, `zf_o`, `bit_index_o` and `valid_o` are all 0.
- R2: `valid_o` is 1 in the cycle after a cycle with `start_i` high, and 0 otherwise. The registered outputs change only on a clock edge where `start_i` is high.
- R3: The test operation (op 0), and the unused op codes 6 and 7, copy the addressed bit into `cf_o` and return the operand unchanged on `result_o`.
- R4: The set (op 1), clear (op 2) and flip (op 3) operations copy the addressed bit's prior value into `cf_o`. They return the operand with that one bit forced to 1, forced to 0, or inverted, respectively.
- R5: The bit position is `index_i` modulo the operand width: all 5 bits are used in 32-bit mode, and only `index_i[3:0]` in 16-bit mode.
- R6: The forward scan (op 4) returns on `bit_index_o` the position of the lowest set bit of the source.
- R7: The reverse scan (op 5) returns on `bit_index_o` the position of the highest set bit of the source.
- R8: A scan sets `zf_o` to 1 when the source is non-zero and to 0 when it is zero. On a zero source, `bit_index_o` keeps its previous value.
- R9: With `wide_i`=0 (16-bit mode), bits 31:16 pass to `result_o` unchanged, and a scan considers only bits 15:0. `wide_i`=1 selects 32-bit mode.
- R10: A scan leaves `cf_o` unchanged. A test-type operation (ops 0-3, 6, 7) leaves `zf_o` and `bit_index_o` unchanged. A scan returns the operand unchanged on `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Issue an operation this cycle |
| op_i | input | 3 | Operation code (see R3, R4, R6, R7) |
| wide_i | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| operand_i | input | 32 | Source operand |
| index_i | input | 5 | Bit position for test operations |
| result_o | output | 32 | Registered operand result |
| cf_o | output | 1 | Registered carry flag (tested bit) |
| zf_o | output | 1 | Registered zero flag (scan source non-zero) |
| bit_index_o | output | 5 | Registered scan result position |
| valid_o | output | 1 | One-cycle pulse after start |

## Verification
The bench targets the following corner cases, each of which exposes a specific class of error:
- **Scans with a single set bit at either end, or with all bits set.** A priority encoder searching in the wrong direction returns the opposite end.
- **Zero source.** A design that writes a default index instead of holding its previous value fails here.
- **16-bit mode with an index bit 4 set and upper operand bits set.** A design that does not mask the index to 4 bits modifies an upper bit. A design that lets the upper half into a scan reports a position above 15.
- **Mixed sequences of tests and scans.** A design that lets one operation class clobber the other class's flag fails these sequences.

// File: rtl/bit_ops_pkg.sv
package bit_ops_pkg;
  typedef enum logic [2:0] {
    OP_TEST  = 3'd0,
    OP_SET   = 3'd1,
    OP_CLR   = 3'd2,
    OP_FLIP  = 3'd3,
    OP_SCANF = 3'd4,
    OP_SCANR = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } bit_op_e;

  function automatic logic is_scan(input logic [2:0] op);
    return (op == OP_SCANF) || (op == OP_SCANR);
  endfunction
endpackage

// File: rtl/bit_modify.sv
module bit_modify #(
  parameter int WIDTH = 32,
  localparam int IdxW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [IdxW-1:0]  index_i,
  input  logic             wide_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             tested_o
);
  import bit_ops_pkg::*;

  logic [IdxW-1:0]  pos;
  logic [WIDTH-1:0] onehot;

  // narrow mode drops the top index bit
  always_comb begin
    pos = index_i;
    if (!wide_i) pos[IdxW-1] = 1'b0;
  end

  assign onehot   = {{(WIDTH-1){1'b0}}, 1'b1} << pos;
  assign tested_o = operand_i[pos];

  always_comb begin
    unique case (op_i)
      OP_SET:  result_o = operand_i | onehot;
      OP_CLR:  result_o = operand_i & ~onehot;
      OP_FLIP: result_o = operand_i ^ onehot;
      default: result_o = operand_i;
    endcase
  end
endmodule

// File: rtl/bit_scan.sv
module bit_scan #(
  parameter int WIDTH = 32,
  localparam int IdxW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] src_i,
  input  logic             reverse_i,
  output logic             found_o,
  output logic [IdxW-1:0]  pos_o
);
  logic [IdxW-1:0] lo_pos, hi_pos;

  // lowest set bit: scan downward so the last hit wins
  always_comb begin
    lo_pos = '0;
    for (int i = WIDTH - 1; i >= 0; i--)
      if (src_i[i]) lo_pos = IdxW'(i);
  end

  // highest set bit: scan upward so the last hit wins
  always_comb begin
    hi_pos = '0;
    for (int i = 0; i < WIDTH; i++)
      if (src_i[i]) hi_pos = IdxW'(i);
  end

  assign found_o = |src_i;
  assign pos_o   = reverse_i ? hi_pos : lo_pos;
endmodule

// File: rtl/bit_ops_unit.sv
module bit_ops_unit #(
  parameter int WIDTH = 32,
  localparam int IdxW = $clog2(WIDTH),
  localparam int Half = WIDTH / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic             wide_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic [IdxW-1:0]  index_i,
  output logic [WIDTH-1:0] result_o,
  output logic             cf_o,
  output logic             zf_o,
  output logic [IdxW-1:0]  bit_index_o,
  output logic             valid_o
);
  import bit_ops_pkg::*;

  logic [WIDTH-1:0] mod_res, scan_src;
  logic             mod_bit, scan_found;
  logic [IdxW-1:0]  scan_pos;

  bit_modify #(.WIDTH(WIDTH)) u_modify (
    .operand_i (operand_i),
    .index_i   (index_i),
    .wide_i    (wide_i),
    .op_i      (op_i),
    .result_o  (mod_res),
    .tested_o  (mod_bit)
  );

  assign scan_src = wide_i ? operand_i : {{(WIDTH-Half){1'b0}}, operand_i[Half-1:0]};

  bit_scan #(.WIDTH(WIDTH)) u_scan (
    .src_i     (scan_src),
    .reverse_i (op_i == OP_SCANR),
    .found_o   (scan_found),
    .pos_o     (scan_pos)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      cf_o        <= 1'b0;
      zf_o        <= 1'b0;
      bit_index_o <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        if (is_scan(op_i)) begin
          result_o <= operand_i;
          zf_o     <= scan_found;
          if (scan_found) bit_index_o <= scan_pos;
        end else begin
          result_o <= mod_res;
          cf_o     <= mod_bit;
        end
      end
    end
  end

  p_valid_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o) && $stable(cf_o) && $stable(zf_o) && $stable(bit_index_o));

  p_test_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && op_i == OP_TEST |=> result_o == $past(operand_i));

  p_one_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !is_scan(op_i) |=> $countones(result_o ^ $past(operand_i)) <= 1);

  p_zero_scan_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && is_scan(op_i) && scan_src == '0 |=> !zf_o && $stable(bit_index_o));

  p_upper_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !wide_i |=> result_o[WIDTH-1:Half] == $past(operand_i[WIDTH-1:Half]));

  p_scan_keeps_cf_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && is_scan(op_i) |=> $stable(cf_o));
endmodule

// File: tb/bit_ops_unit_tb.sv
module bit_ops_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic        wide = 1'b1;
  logic [31:0] opnd = '0;
  logic [4:0]  idx = '0;
  logic [31:0] result;
  logic        cf, zf, valid;
  logic [4:0]  bidx;

  int checks = 0;
  int fails  = 0;
  logic [31:0] e_res = '0;
  logic        e_cf = 1'b0, e_zf = 1'b0;
  logic [4:0]  e_idx = '0;

  always #2 clk = ~clk;

  bit_ops_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .wide_i(wide),
    .operand_i(opnd), .index_i(idx), .result_o(result), .cf_o(cf), .zf_o(zf),
    .bit_index_o(bidx), .valid_o(valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, updates expected state
  task automatic model(input logic [2:0] o, input logic w, input logic [31:0] a, input logic [4:0] k);
    logic [4:0]  p;
    logic [31:0] src;
    p = w ? k : {1'b0, k[3:0]};
    if (o == 3'd4 || o == 3'd5) begin
      src = w ? a : {16'h0, a[15:0]};
      e_res = a;
      e_zf = (src != 0);
      if (src != 0) begin
        if (o == 3'd4) begin
          for (int i = 0; i < 32; i++) if (src[i]) begin e_idx = 5'(i); break; end
        end else begin
          for (int i = 31; i >= 0; i--) if (src[i]) begin e_idx = 5'(i); break; end
        end
      end
    end else begin
      e_cf = a[p];
      e_res = a;
      case (o)
        3'd1: e_res[p] = 1'b1;
        3'd2: e_res[p] = 1'b0;
        3'd3: e_res[p] = ~a[p];
        default: ;
      endcase
    end
  endtask

  task automatic run(input string tag, input logic [2:0] o, input logic w,
                     input logic [31:0] a, input logic [4:0] k);
    @(negedge clk);
    op = o; wide = w; opnd = a; idx = k; start = 1'b1;
    model(o, w, a, k);
    @(negedge clk);
    start = 1'b0;
    opnd = ~a; idx = ~k;
    chk({tag, " valid R2"}, {31'h0, valid}, 32'h1);
    chk({tag, " result"}, result, e_res);
    chk({tag, " cf"}, {31'h0, cf}, {31'h0, e_cf});
    chk({tag, " zf"}, {31'h0, zf}, {31'h0, e_zf});
    chk({tag, " index"}, {27'h0, bidx}, {27'h0, e_idx});
    @(negedge clk);
    chk({tag, " valid drop R2"}, {31'h0, valid}, 32'h0);
    chk({tag, " hold R2"}, result, e_res);
  endtask

  task automatic t_reset;
    chk("R1 result", result, 32'h0);
    chk("R1 flags", {28'h0, cf, zf, valid, 1'b0}, 32'h0);
    chk("R1 index", {27'h0, bidx}, 32'h0);
  endtask

  task automatic t_test;
    run("R3 test bit set", 3'd0, 1'b1, 32'h8000_0001, 5'd31);
    run("R3 test bit clear", 3'd0, 1'b1, 32'h8000_0001, 5'd7);
    run("R3 rsv op6", 3'd6, 1'b1, 32'h0000_0100, 5'd8);
    run("R3 rsv op7", 3'd7, 1'b1, 32'hFFFF_FFFF, 5'd3);
  endtask

  task automatic t_modify;
    run("R4 set", 3'd1, 1'b1, 32'h0000_0000, 5'd17);
    run("R4 set already", 3'd1, 1'b1, 32'h0002_0000, 5'd17);
    run("R4 clear", 3'd2, 1'b1, 32'hFFFF_FFFF, 5'd0);
    run("R4 flip on", 3'd3, 1'b1, 32'h1234_5678, 5'd31);
    run("R4 flip off", 3'd3, 1'b1, 32'h1234_5678, 5'd3);
  endtask

  task automatic t_modulo;
    run("R5 narrow idx20", 3'd1, 1'b0, 32'h0000_0000, 5'd20);
    run("R5 narrow idx31 test", 3'd0, 1'b0, 32'h8000_8000, 5'd31);
    run("R5 wide idx20", 3'd1, 1'b1, 32'h0000_0000, 5'd20);
  endtask

  task automatic t_scans;
    run("R6 fwd lsb", 3'd4, 1'b1, 32'h8000_0001, 5'd0);
    run("R6 fwd mid", 3'd4, 1'b1, 32'hF000_0400, 5'd0);
    run("R6 fwd msb", 3'd4, 1'b1, 32'h8000_0000, 5'd0);
    run("R7 rev msb", 3'd5, 1'b1, 32'h8000_0001, 5'd0);
    run("R7 rev lsb", 3'd5, 1'b1, 32'h0000_0001, 5'd0);
    run("R7 rev all", 3'd5, 1'b1, 32'hFFFF_FFFF, 5'd0);
    run("R8 zero fwd holds", 3'd4, 1'b1, 32'h0000_0000, 5'd0);
    run("R8 zero rev holds", 3'd5, 1'b1, 32'h0000_0000, 5'd0);
  endtask

  task automatic t_narrow;
    run("R9 narrow flip upper pass", 3'd3, 1'b0, 32'hABCD_0000, 5'd15);
    run("R9 narrow rev ignores upper", 3'd5, 1'b0, 32'hFFFF_0012, 5'd0);
    run("R9 narrow zero low", 3'd4, 1'b0, 32'hFFFF_0000, 5'd0);
  endtask

  task automatic t_cross;
    run("R10 test sets cf", 3'd0, 1'b1, 32'h0000_0010, 5'd4);
    run("R10 scan keeps cf", 3'd4, 1'b1, 32'h0000_0600, 5'd0);
    run("R10 test keeps zf idx", 3'd2, 1'b1, 32'h0000_0000, 5'd9);
  endtask

  initial begin
    #1;
    t_reset();
    #10 rst_n = 1'b1;
    t_test();
    t_modify();
    t_modulo();
    t_scans();
    t_narrow();
    t_cross();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule